// File: doc/BRIEF.md
# Serial In-System Memory Programming Controller

This block is the device-side end of a three-wire serial programming link. An external programmer holds the device reset pin low, then clocks four-byte instructions in on MOSI against SCK. The controller reads them and returns bytes on MISO. The instructions can unlock the controller, erase all storage, write or read single bytes of a program array and a data array, and ask whether the last erase or write has finished. Both arrays are plain byte arrays inside the block.

SCK and MOSI are not used as clocks. They are oversampled by the local system clock through a synchronizer, and the edges of SCK are found by comparison. The programmer must therefore hold each SCK phase for several system clock cycles. Programming operations are self-timed: after an erase or a write the block reports itself busy for a fixed number of system clocks. During that window it refuses further modifying instructions but still serves reads.

Top module: `spi_prog_ctrl`

## Requirements
- R1: The link is live only while `prog_rst_n` is low. While it is high, `miso_oe` and `miso` are 0. Raising it in the middle of an instruction discards the partial instruction and clears the unlocked state, so the next instruction starts on a byte boundary.
- R2: Every instruction is 4 bytes, shifted most significant bit first. MOSI is taken at each SCK rising edge, and MISO moves only after SCK falling edges.
- R3: Instruction bytes 0xAC, 0x53, any, any unlock the controller. During the third byte of every instruction, MISO returns the second byte received, so an unlock instruction echoes 0x53 there.
- R4: Until an unlock instruction completes, erase and write instructions have no effect, and the fourth-byte response of read and poll instructions is 0x00.
- R5: Chip erase (0xAC, 0x80, any, any) sets every byte of both arrays to 0xFF.
- R6: A data write (0xC0, 0x00, addr, value) leaves exactly `value` at the location, whatever it held before.
- R7: A program write (0x40, 0x00, addr, value) leaves the bitwise AND of the old content and `value`.
- R8: A program read (0x20, 0x00, addr, any) or a data read (0xA0, 0x00, addr, any) returns the addressed byte during the fourth byte. Only the low PROG_AW or DATA_AW bits of the third byte form the address.
- R9: An accepted erase or write makes the block busy for BUSY_CYCLES system clocks. Erase and write instructions that arrive while it is busy are ignored. Reads are served while busy.
- R10: A poll (0xF0, 0x00, any, any) returns 0x01 in the fourth byte while busy and 0x00 when idle.
- R11: Instructions are received correctly when each SCK phase lasts at least SYNC_STAGES+2 system clock cycles.
- R12: After system reset both arrays hold 0x00 and the controller is locked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low system reset |
| prog_rst_n | input | 1 | Device reset pin; the link is live while it is low |
| sck | input | 1 | Serial clock from the programmer |
| mosi | input | 1 | Serial data from the programmer |
| miso | output | 1 | Serial data to the programmer |
| miso_oe | output | 1 | Output enable for miso |

## Verification
The bench writes and reads back every data address and a span of program addresses. Each program location is written twice, so a design that overwrites instead of ANDing, or that ANDs on the data array and skips the auto-erase, returns wrong bytes. It sends erase and write instructions before unlocking and after a failed unlock, and also a second write while busy; a design that leaks any of these changes array contents that are read later. It cuts the link in the middle of an instruction. A design that keeps its bit or byte count, or its unlocked state, then answers the following reads out of frame or without a fresh unlock.

// File: rtl/spi_prog_pkg.sv
package spi_prog_pkg;

  localparam logic [7:0] OPC_UNLOCK_HI = 8'hAC;
  localparam logic [7:0] KEY_UNLOCK    = 8'h53;
  localparam logic [7:0] KEY_ERASE     = 8'h80;
  localparam logic [7:0] OPC_RD_PROG   = 8'h20;
  localparam logic [7:0] OPC_WR_PROG   = 8'h40;
  localparam logic [7:0] OPC_RD_DATA   = 8'hA0;
  localparam logic [7:0] OPC_WR_DATA   = 8'hC0;
  localparam logic [7:0] OPC_POLL      = 8'hF0;
  localparam logic [7:0] ERASED_BYTE   = 8'hFF;

  typedef enum logic [2:0] {
    CMD_NONE, CMD_UNLOCK, CMD_ERASE, CMD_RD_PROG,
    CMD_WR_PROG, CMD_RD_DATA, CMD_WR_DATA, CMD_POLL
  } cmd_e;

  function automatic cmd_e decode_cmd(input logic [7:0] op, input logic [7:0] sub);
    cmd_e c;
    c = CMD_NONE;
    case (op)
      OPC_UNLOCK_HI: begin
        if (sub == KEY_UNLOCK)     c = CMD_UNLOCK;
        else if (sub == KEY_ERASE) c = CMD_ERASE;
      end
      OPC_RD_PROG: c = CMD_RD_PROG;
      OPC_WR_PROG: c = CMD_WR_PROG;
      OPC_RD_DATA: c = CMD_RD_DATA;
      OPC_WR_DATA: c = CMD_WR_DATA;
      OPC_POLL:    c = CMD_POLL;
      default:     c = CMD_NONE;
    endcase
    return c;
  endfunction

  // Program cells can only clear bits without an erase.
  function automatic logic [7:0] prog_merge(input logic [7:0] old_v, input logic [7:0] new_v);
    return old_v & new_v;
  endfunction

endpackage

// File: rtl/spi_prog_sync.sv
module spi_prog_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sck_i,
  input  logic mosi_i,
  input  logic prog_rst_ni,
  output logic sck_rise,
  output logic sck_fall,
  output logic mosi_s,
  output logic link_on
);
  localparam int MSB = STAGES - 1;

  logic [STAGES-1:0] sck_ff, mosi_ff, pin_ff;
  logic              sck_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_ff   <= '0;
      mosi_ff  <= '0;
      pin_ff   <= '1;
      sck_prev <= 1'b0;
    end else begin
      sck_ff   <= {sck_ff[STAGES-2:0], sck_i};
      mosi_ff  <= {mosi_ff[STAGES-2:0], mosi_i};
      pin_ff   <= {pin_ff[STAGES-2:0], prog_rst_ni};
      sck_prev <= sck_ff[MSB];
    end
  end

  assign link_on  = ~pin_ff[MSB];
  assign mosi_s   = mosi_ff[MSB];
  assign sck_rise = link_on &  sck_ff[MSB] & ~sck_prev;
  assign sck_fall = link_on & ~sck_ff[MSB] &  sck_prev;

  // R11
  edge_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sck_rise |=> !sck_fall);

endmodule

// File: rtl/spi_prog_shifter.sv
module spi_prog_shifter #(
  parameter int BYTES = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  link_on,
  input  logic                  sck_rise,
  input  logic                  sck_fall,
  input  logic                  mosi_s,
  input  logic [7:0]            resp_i,
  output logic [BYTES-1:0][7:0] rx_bytes,
  output logic                  hdr_ready,
  output logic                  instr_done,
  output logic                  miso_q
);
  localparam int              BW       = $clog2(BYTES);
  localparam logic [BW-1:0]   LAST_IDX = BW'(BYTES - 1);
  localparam logic [BW-1:0]   HDR_IDX  = BW'(BYTES - 2);
  localparam logic [BW-1:0]   ECHO_IDX = BW'(1);

  logic [2:0]    bit_cnt;
  logic [BW-1:0] byte_cnt;
  logic [7:0]    sr, tx_byte;
  logic [7:0]    sr_next;
  logic          byte_end;

  assign sr_next  = {sr[6:0], mosi_s};
  assign byte_end = sck_rise && (bit_cnt == 3'd7);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_cnt    <= '0;
      byte_cnt   <= '0;
      sr         <= '0;
      tx_byte    <= '0;
      miso_q     <= 1'b0;
      hdr_ready  <= 1'b0;
      instr_done <= 1'b0;
      rx_bytes   <= '0;
    end else if (!link_on) begin
      bit_cnt    <= '0;
      byte_cnt   <= '0;
      sr         <= '0;
      tx_byte    <= '0;
      miso_q     <= 1'b0;
      hdr_ready  <= 1'b0;
      instr_done <= 1'b0;
    end else begin
      hdr_ready  <= 1'b0;
      instr_done <= 1'b0;
      if (hdr_ready) tx_byte <= resp_i;
      if (sck_rise) begin
        sr      <= sr_next;
        bit_cnt <= bit_cnt + 3'd1;
        if (byte_end) begin
          rx_bytes[byte_cnt] <= sr_next;
          byte_cnt   <= (byte_cnt == LAST_IDX) ? '0 : byte_cnt + 1'b1;
          tx_byte    <= (byte_cnt == ECHO_IDX) ? sr_next : 8'h00;
          hdr_ready  <= (byte_cnt == HDR_IDX);
          instr_done <= (byte_cnt == LAST_IDX);
        end
      end else if (sck_fall) begin
        miso_q <= tx_byte[~bit_cnt];
      end
    end
  end

  // R2
  miso_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (link_on && !$past(sck_fall)) |-> (miso_q == $past(miso_q) || !$past(link_on)));

  // R2
  done_after_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    instr_done |-> $past(sck_rise));

endmodule

// File: rtl/spi_prog_array.sv
module spi_prog_array
  import spi_prog_pkg::*;
#(
  parameter int AW    = 5,
  parameter bit MERGE = 1'b0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          erase,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [7:0]    wdata,
  output logic [7:0]    rdata
);
  localparam int DEPTH = 1 << AW;

  logic [7:0] cells [DEPTH];
  logic [7:0] new_v;

  assign rdata = cells[addr];

  generate
    if (MERGE) begin : g_and
      assign new_v = prog_merge(rdata, wdata);
      // R7
      prog_and_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (we && !erase) |=> rdata == ($past(rdata) & $past(wdata)));
    end else begin : g_over
      assign new_v = wdata;
      // R6
      data_over_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (we && !erase) |=> rdata == $past(wdata));
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) cells[i] <= 8'h00;
    end else if (erase) begin
      for (int i = 0; i < DEPTH; i++) cells[i] <= ERASED_BYTE;
    end else if (we) begin
      cells[addr] <= new_v;
    end
  end

  // R5
  erase_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    erase |=> rdata == 8'hFF);

endmodule

// File: rtl/spi_prog_engine.sv
module spi_prog_engine
  import spi_prog_pkg::*;
#(
  parameter int BYTES       = 4,
  parameter int PROG_AW     = 6,
  parameter int DATA_AW     = 5,
  parameter int BUSY_CYCLES = 600
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  link_on,
  input  logic                  instr_done,
  input  logic [BYTES-1:0][7:0] rx_bytes,
  input  logic [7:0]            prog_rdata,
  input  logic [7:0]            data_rdata,
  output logic [7:0]            resp,
  output logic                  erase_o,
  output logic                  prog_we,
  output logic                  data_we,
  output logic [PROG_AW-1:0]    prog_addr,
  output logic [DATA_AW-1:0]    data_addr,
  output logic [7:0]            wdata
);
  localparam int CW = $clog2(BUSY_CYCLES + 1);

  cmd_e          cmd;
  logic          enabled;
  logic [CW-1:0] busy_cnt;
  logic          busy;
  logic          is_modify;
  logic          unlock_evt;
  logic          modify_evt;
  logic          spare_unused;

  assign cmd          = decode_cmd(rx_bytes[0], rx_bytes[1]);
  assign prog_addr    = rx_bytes[2][PROG_AW-1:0];
  assign data_addr    = rx_bytes[2][DATA_AW-1:0];
  assign wdata        = rx_bytes[3];
  assign spare_unused = ^rx_bytes;

  assign busy       = (busy_cnt != '0);
  assign is_modify  = (cmd == CMD_ERASE) || (cmd == CMD_WR_PROG) || (cmd == CMD_WR_DATA);
  assign unlock_evt = instr_done && (cmd == CMD_UNLOCK);
  assign modify_evt = instr_done && enabled && !busy && is_modify;

  assign erase_o = modify_evt && (cmd == CMD_ERASE);
  assign prog_we = modify_evt && (cmd == CMD_WR_PROG);
  assign data_we = modify_evt && (cmd == CMD_WR_DATA);

  always_comb begin
    resp = 8'h00;
    if (enabled) begin
      case (cmd)
        CMD_RD_PROG: resp = prog_rdata;
        CMD_RD_DATA: resp = data_rdata;
        CMD_POLL:    resp = {7'b0, busy};
        default:     resp = 8'h00;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      enabled <= 1'b0;
    end else if (!link_on) begin
      enabled <= 1'b0;
    end else if (unlock_evt) begin
      enabled <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_cnt <= '0;
    end else if (modify_evt) begin
      busy_cnt <= CW'(BUSY_CYCLES);
    end else if (busy) begin
      busy_cnt <= busy_cnt - 1'b1;
    end
  end

  // R1
  lock_on_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !link_on |=> !enabled);

  // R9
  busy_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(instr_done && enabled));

  // R4
  strobe_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (erase_o || prog_we || data_we) |-> (enabled && $past(!busy || busy_cnt == 1)));

endmodule

// File: rtl/spi_prog_ctrl.sv
module spi_prog_ctrl #(
  parameter int PROG_AW     = 6,
  parameter int DATA_AW     = 5,
  parameter int BUSY_CYCLES = 600,
  parameter int SYNC_STAGES = 2,
  parameter int INSTR_BYTES = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic prog_rst_n,
  input  logic sck,
  input  logic mosi,
  output logic miso,
  output logic miso_oe
);
  logic                        sck_rise, sck_fall, mosi_s, link_on;
  logic [INSTR_BYTES-1:0][7:0] rx_bytes;
  logic                        hdr_ready, instr_done, miso_q;
  logic [7:0]                  resp, wdata, prog_rdata, data_rdata;
  logic                        erase_s, prog_we, data_we;
  logic [PROG_AW-1:0]          prog_addr;
  logic [DATA_AW-1:0]          data_addr;

  spi_prog_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .sck_i(sck), .mosi_i(mosi), .prog_rst_ni(prog_rst_n),
    .sck_rise(sck_rise), .sck_fall(sck_fall), .mosi_s(mosi_s), .link_on(link_on)
  );

  spi_prog_shifter #(.BYTES(INSTR_BYTES)) u_shift (
    .clk(clk), .rst_n(rst_n), .link_on(link_on), .sck_rise(sck_rise),
    .sck_fall(sck_fall), .mosi_s(mosi_s), .resp_i(resp), .rx_bytes(rx_bytes),
    .hdr_ready(hdr_ready), .instr_done(instr_done), .miso_q(miso_q)
  );

  spi_prog_engine #(
    .BYTES(INSTR_BYTES), .PROG_AW(PROG_AW), .DATA_AW(DATA_AW), .BUSY_CYCLES(BUSY_CYCLES)
  ) u_eng (
    .clk(clk), .rst_n(rst_n), .link_on(link_on), .instr_done(instr_done),
    .rx_bytes(rx_bytes), .prog_rdata(prog_rdata), .data_rdata(data_rdata),
    .resp(resp), .erase_o(erase_s), .prog_we(prog_we), .data_we(data_we),
    .prog_addr(prog_addr), .data_addr(data_addr), .wdata(wdata)
  );

  spi_prog_array #(.AW(PROG_AW), .MERGE(1'b1)) u_prog (
    .clk(clk), .rst_n(rst_n), .erase(erase_s), .we(prog_we),
    .addr(prog_addr), .wdata(wdata), .rdata(prog_rdata)
  );

  spi_prog_array #(.AW(DATA_AW), .MERGE(1'b0)) u_data (
    .clk(clk), .rst_n(rst_n), .erase(erase_s), .we(data_we),
    .addr(data_addr), .wdata(wdata), .rdata(data_rdata)
  );

  assign miso    = link_on & miso_q;
  assign miso_oe = link_on;

  // R1
  quiet_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(prog_rst_n) && prog_rst_n && $past(prog_rst_n, 2) && $past(prog_rst_n, 3)
      |-> (!miso_oe && !miso));

  // R3
  echo_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hdr_ready |-> !instr_done);

endmodule

// File: tb/sim_spi_prog_ctrl.sv
module sim_spi_prog_ctrl;
  localparam int PH = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic prog_rst_n = 1'b1;
  logic sck = 1'b0;
  logic mosi = 1'b0;
  logic miso, miso_oe;

  int checks = 0;
  int errors = 0;

  logic [7:0] pm [64];
  logic [7:0] dm [32];

  always #10 clk = ~clk;

  spi_prog_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .prog_rst_n(prog_rst_n),
    .sck(sck), .mosi(mosi), .miso(miso), .miso_oe(miso_oe)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic send_byte(input logic [7:0] tx, output logic [7:0] rx);
    for (int i = 7; i >= 0; i--) begin
      @(negedge clk);
      mosi = tx[i];
      repeat (PH - 1) @(negedge clk);
      rx[i] = miso;
      sck = 1'b1;
      repeat (PH) @(negedge clk);
      sck = 1'b0;
    end
  endtask

  task automatic instr(input logic [7:0] a, input logic [7:0] b, input logic [7:0] c,
                       input logic [7:0] d, output logic [7:0] r2, output logic [7:0] r3);
    logic [7:0] x;
    send_byte(a, x);
    send_byte(b, x);
    send_byte(c, r2);
    send_byte(d, r3);
    repeat (2) @(negedge clk);
  endtask

  task automatic wait_idle();
    logic [7:0] r2, r3;
    int n;
    n = 0;
    do begin
      instr(8'hF0, 8'h00, 8'h00, 8'h00, r2, r3);
      n++;
    end while (r3 != 8'h00 && n < 20);
    chk("R10 poll reaches idle", r3, 8'h00);
  endtask

  initial begin
    repeat (180000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] r2, r3, e;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    // R1 R12: link off after reset
    chk("R1 oe off while pin high", {7'b0, miso_oe}, 8'h00);
    chk("R1 miso low while pin high", {7'b0, miso}, 8'h00);
    prog_rst_n = 1'b0;
    repeat (6) @(negedge clk);
    chk("R1 oe on while pin low", {7'b0, miso_oe}, 8'h01);

    // R4: locked, modifications ignored, read/poll answer zero
    instr(8'hC0, 8'h00, 8'h01, 8'h55, r2, r3);
    instr(8'hAC, 8'h80, 8'h00, 8'h00, r2, r3);
    instr(8'hF0, 8'h00, 8'h00, 8'h00, r2, r3);
    chk("R4 poll while locked", r3, 8'h00);
    // R3: failed unlock key, erase after it must still be ignored
    instr(8'hAC, 8'h52, 8'h00, 8'h00, r2, r3);
    chk("R3 echo of second byte", r2, 8'h52);
    instr(8'hAC, 8'h80, 8'h00, 8'h00, r2, r3);

    instr(8'hAC, 8'h53, 8'h00, 8'h00, r2, r3);
    chk("R3 unlock echo", r2, 8'h53);
    instr(8'hA0, 8'h00, 8'h01, 8'h00, r2, r3);
    chk("R4 R12 data untouched before unlock", r3, 8'h00);
    instr(8'h20, 8'h00, 8'h07, 8'h00, r2, r3);
    chk("R4 R12 prog untouched before unlock", r3, 8'h00);

    // R5 R10: chip erase, poll busy
    instr(8'hAC, 8'h80, 8'h00, 8'h00, r2, r3);
    instr(8'hF0, 8'h00, 8'h00, 8'h00, r2, r3);
    chk("R10 poll busy after erase", r3, 8'h01);
    wait_idle();
    for (int a = 0; a < 64; a++) begin
      pm[a] = 8'hFF;
      instr(8'h20, 8'h00, 8'(a), 8'h00, r2, r3);
      chk("R5 R8 prog erased", r3, 8'hFF);
    end
    for (int a = 0; a < 32; a++) begin
      dm[a] = 8'hFF;
      instr(8'hA0, 8'h00, 8'(a), 8'h00, r2, r3);
      chk("R5 R8 data erased", r3, 8'hFF);
    end

    // R9: write while busy ignored, read while busy served
    instr(8'hC0, 8'h00, 8'h00, 8'h12, r2, r3);
    dm[0] = 8'h12;
    instr(8'hC0, 8'h00, 8'h01, 8'h34, r2, r3);
    instr(8'hA0, 8'h00, 8'h00, 8'h00, r2, r3);
    chk("R9 read served while busy", r3, 8'h12);
    wait_idle();
    instr(8'hA0, 8'h00, 8'h01, 8'h00, r2, r3);
    chk("R9 write during busy ignored", r3, 8'hFF);

    // R6: data sweep and auto-erase overwrite
    for (int a = 0; a < 32; a++) begin
      e = 8'((a * 37 + 11) & 255);
      dm[a] = e;
      instr(8'hC0, 8'h00, 8'(a), e, r2, r3);
      wait_idle();
    end
    instr(8'hC0, 8'h00, 8'h03, 8'h0F, r2, r3);
    wait_idle();
    instr(8'hC0, 8'h00, 8'h03, 8'hF0, r2, r3);
    wait_idle();
    dm[3] = 8'hF0;
    for (int a = 0; a < 32; a++) begin
      instr(8'hA0, 8'h00, 8'(a), 8'h00, r2, r3);
      chk("R6 R8 data readback", r3, dm[a]);
    end

    // R7: program writes AND into old content
    for (int a = 0; a < 16; a++) begin
      e = 8'((a * 53 + 7) & 255);
      pm[a] = pm[a] & e;
      instr(8'h40, 8'h00, 8'(a), e, r2, r3);
      wait_idle();
      e = 8'((a * 29 + 200) & 255);
      pm[a] = pm[a] & e;
      instr(8'h40, 8'h00, 8'(a), e, r2, r3);
      wait_idle();
    end
    for (int a = 0; a < 16; a++) begin
      instr(8'h20, 8'h00, 8'(a), 8'h00, r2, r3);
      chk("R7 prog AND readback", r3, pm[a]);
    end
    // R8: upper address bits ignored
    instr(8'h20, 8'h00, 8'h45, 8'h00, r2, r3);
    chk("R8 prog address wraps", r3, pm[5]);
    instr(8'hA0, 8'h00, 8'hE2, 8'h00, r2, r3);
    chk("R8 data address wraps", r3, dm[2]);

    // R1 R2: abort mid-instruction, relock, reframe
    send_byte(8'hC0, e);
    send_byte(8'h00, e);
    prog_rst_n = 1'b1;
    repeat (6) @(negedge clk);
    chk("R1 oe off after release", {7'b0, miso_oe}, 8'h00);
    prog_rst_n = 1'b0;
    repeat (6) @(negedge clk);
    instr(8'hA0, 8'h00, 8'h02, 8'h00, r2, r3);
    chk("R1 relocked after release", r3, 8'h00);
    instr(8'hAC, 8'h53, 8'h00, 8'h00, r2, r3);
    chk("R1 R3 echo after reframe", r2, 8'h53);
    instr(8'hA0, 8'h00, 8'h02, 8'h00, r2, r3);
    chk("R2 R11 framed read after abort", r3, dm[2]);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule